// File: doc/BRIEF.md
# Execute-Stage Operand Bypass

This block picks, for each of the two ALU operands of the instruction entering execute, where that operand's value comes from. It compares the instruction's two source register numbers with the destination registers of the two older instructions still in flight. One of those instructions sits between execute and memory. The other sits between memory and writeback. The block returns a 2-bit select code per operand and the operand values those codes choose.

The logic is purely combinational. The codes and operands follow the pipeline registers of the current cycle with no added latency. The outputs feed the ALU input directly. Dependent register-to-register instructions issued back to back therefore run without a stall. Stall generation and the register file are outside this block.

Top module: `operand_bypass`

## Requirements
- R1: When the execute/memory stage has its write flag set and its destination equals a source register, that operand's select code is 2'b10 and the operand equals the execute/memory result.
- R2: A destination of register 0 is never forwarded from either stage. The operand then falls back to the other stage or to the register-file value.
- R3: When the execute/memory stage does not match but the memory/writeback stage has its write flag set and a nonzero destination equal to the source register, the select code is 2'b01 and the operand equals the writeback value.
- R4: When both stages qualify for the same source register, the execute/memory result wins and the code is 2'b10.
- R5: With no qualifying stage, the select code is 2'b00 and the operand equals the register-file read value for that source.
- R6: A stage whose write flag is 0 is never forwarded, even when its destination matches.
- R7: Operand A uses rs and operand B uses rt. Each is decided separately under the same rules, so the two may take different sources in the same cycle.
- R8: The outputs follow input changes within the same cycle, with no register on the path.
- R9: The select code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | REG_W | First source register of the instruction entering execute |
| ex_rt | input | REG_W | Second source register of the instruction entering execute |
| mem_wen | input | 1 | Register-write flag of the execute/memory stage |
| mem_rd | input | REG_W | Destination register of the execute/memory stage |
| wb_wen | input | 1 | Register-write flag of the memory/writeback stage |
| wb_rd | input | REG_W | Destination register of the memory/writeback stage |
| rf_a | input | DATA_W | Register-file value read for rs |
| rf_b | input | DATA_W | Register-file value read for rt |
| mem_result | input | DATA_W | ALU result held in the execute/memory stage |
| wb_value | input | DATA_W | Value being written back by the memory/writeback stage |
| op_a | output | DATA_W | Operand A delivered to the ALU |
| op_b | output | DATA_W | Operand B delivered to the ALU |
| sel_a | output | 2 | Source code for operand A (00 file, 01 writeback, 10 execute/memory) |
| sel_b | output | 2 | Source code for operand B (same encoding) |

## Verification
The checker watches every input change. It checks that a code never reaches 11, that each nonzero code is backed by an enabled stage with a nonzero matching destination, and that a qualifying execute/memory stage always takes priority. It also checks that each operand carries the value its code names. Only the bench sweep can show that the fallback to the register file happens exactly when nothing qualifies. It also shows that the two operands pick different sources in the same cycle, and that the outputs settle in the cycle the inputs change.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [REG_W-1:0]  ex_rs,
  input  logic [REG_W-1:0]  ex_rt,
  input  logic              mem_wen,
  input  logic [REG_W-1:0]  mem_rd,
  input  logic              wb_wen,
  input  logic [REG_W-1:0]  wb_rd,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] mem_result,
  input  logic [DATA_W-1:0] wb_value,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b
);
  localparam logic [1:0] SEL_FILE = 2'b00;
  localparam logic [1:0] SEL_WB   = 2'b01;
  localparam logic [1:0] SEL_MEM  = 2'b10;

  logic              mem_live, wb_live;
  logic [REG_W-1:0]  src  [2];
  logic [DATA_W-1:0] file [2];
  logic [DATA_W-1:0] pick [2];
  logic [1:0]        code [2];

  assign mem_live = mem_wen && (mem_rd != '0);
  assign wb_live  = wb_wen  && (wb_rd  != '0);

  assign src[0]  = ex_rs;
  assign src[1]  = ex_rt;
  assign file[0] = rf_a;
  assign file[1] = rf_b;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    always_comb begin
      if (mem_live && mem_rd == src[g])
        code[g] = SEL_MEM;
      else if (wb_live && wb_rd == src[g])
        code[g] = SEL_WB;
      else
        code[g] = SEL_FILE;
    end

    always_comb begin
      unique case (code[g])
        SEL_MEM: pick[g] = mem_result;
        SEL_WB:  pick[g] = wb_value;
        default: pick[g] = file[g];
      endcase
    end
  end

  assign sel_a = code[0];
  assign sel_b = code[1];
  assign op_a  = pick[0];
  assign op_b  = pick[1];
endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic [REG_W-1:0]  ex_rs,
  input logic [REG_W-1:0]  ex_rt,
  input logic              mem_wen,
  input logic [REG_W-1:0]  mem_rd,
  input logic              wb_wen,
  input logic [REG_W-1:0]  wb_rd,
  input logic [DATA_W-1:0] rf_a,
  input logic [DATA_W-1:0] rf_b,
  input logic [DATA_W-1:0] mem_result,
  input logic [DATA_W-1:0] wb_value,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b
);
  always_comb begin
    AST_SEL_A_LEGAL: assert (sel_a != 2'b11) else $error("sel_a illegal"); // R9
    AST_SEL_B_LEGAL: assert (sel_b != 2'b11) else $error("sel_b illegal"); // R9
    AST_A_MEM_BACKED: assert (sel_a != 2'b10 || (mem_wen && mem_rd != '0 && mem_rd == ex_rs)) else $error("A mem"); // R2
    AST_B_MEM_BACKED: assert (sel_b != 2'b10 || (mem_wen && mem_rd != '0 && mem_rd == ex_rt)) else $error("B mem"); // R6
    AST_A_WB_BACKED: assert (sel_a != 2'b01 || (wb_wen && wb_rd != '0 && wb_rd == ex_rs)) else $error("A wb"); // R3
    AST_B_WB_BACKED: assert (sel_b != 2'b01 || (wb_wen && wb_rd != '0 && wb_rd == ex_rt)) else $error("B wb"); // R3
    AST_A_MEM_PRIO: assert (!(mem_wen && mem_rd != '0 && mem_rd == ex_rs) || sel_a == 2'b10) else $error("A prio"); // R4
    AST_B_MEM_PRIO: assert (!(mem_wen && mem_rd != '0 && mem_rd == ex_rt) || sel_b == 2'b10) else $error("B prio"); // R4
    AST_A_VALUE: assert (op_a == (sel_a == 2'b10 ? mem_result : sel_a == 2'b01 ? wb_value : rf_a)) else $error("A value"); // R1
    AST_B_VALUE: assert (op_b == (sel_b == 2'b10 ? mem_result : sel_b == 2'b01 ? wb_value : rf_b)) else $error("B value"); // R7
  end
endmodule

bind operand_bypass operand_bypass_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_wen(mem_wen), .mem_rd(mem_rd),
  .wb_wen(wb_wen), .wb_rd(wb_rd), .rf_a(rf_a), .rf_b(rf_b),
  .mem_result(mem_result), .wb_value(wb_value),
  .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/operand_bypass_test.sv
module operand_bypass_test;
  localparam int DW = 8;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [RW-1:0] ex_rs, ex_rt, mem_rd, wb_rd;
  logic          mem_wen, wb_wen;
  logic [DW-1:0] rf_a, rf_b, mem_result, wb_value, op_a, op_b;
  logic [1:0]    sel_a, sel_b;

  int tests = 0;
  int fails = 0;

  operand_bypass #(.DATA_W(DW), .REG_W(RW)) uut (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_wen(mem_wen), .mem_rd(mem_rd),
    .wb_wen(wb_wen), .wb_rd(wb_rd), .rf_a(rf_a), .rf_b(rf_b),
    .mem_result(mem_result), .wb_value(wb_value),
    .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b)
  );

  function automatic logic [1:0] want_sel(input logic [RW-1:0] s);
    if (mem_wen && mem_rd != 0 && mem_rd == s) return 2'b10;
    if (wb_wen && wb_rd != 0 && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_for(input logic [RW-1:0] s, input logic [1:0] e);
    if (e == 2'b10) return (wb_wen && wb_rd != 0 && wb_rd == s) ? "R4" : "R1";
    if (e == 2'b01) return "R3";
    if ((mem_rd == s && mem_wen) || (wb_rd == s && wb_wen)) return "R2";
    if (mem_rd == s || wb_rd == s) return "R6";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    ex_rs = 0; ex_rt = 0; mem_rd = 0; wb_rd = 0; mem_wen = 0; wb_wen = 0;
    rf_a = 8'h11; rf_b = 8'h22; mem_result = 8'h33; wb_value = 8'h44;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R5", {6'd0, sel_a}, 8'd0);
    check("R5", op_a, 8'h11);
    check("R5", op_b, 8'h22);

    // R7: A from execute/memory, B from writeback in the same cycle
    @(posedge clk); #1;
    ex_rs = 2'd1; ex_rt = 2'd2; mem_wen = 1; mem_rd = 2'd1; wb_wen = 1; wb_rd = 2'd2;
    @(negedge clk);
    check("R7", op_a, 8'h33);
    check("R7", op_b, 8'h44);
    check("R7", {6'd0, sel_b}, 8'd1);

    // R8: change mid-cycle, outputs follow before the next edge
    @(posedge clk); #1;
    mem_wen = 0;
    #2;
    check("R8", op_a, 8'h11);
    check("R8", {6'd0, sel_a}, 8'd0);

    for (int k = 0; k < 1024; k++) begin
      @(posedge clk); #1;
      ex_rs = k[1:0]; ex_rt = k[3:2]; mem_rd = k[5:4]; wb_rd = k[7:6];
      mem_wen = k[8]; wb_wen = k[9];
      rf_a = k[7:0]; rf_b = ~k[7:0]; mem_result = k[7:0] ^ 8'h5A; wb_value = k[7:0] + 8'h33;
      @(negedge clk);
      begin
        logic [1:0] ea, eb;
        ea = want_sel(ex_rs);
        eb = want_sel(ex_rt);
        check(tag_for(ex_rs, ea), {6'd0, sel_a}, {6'd0, ea});
        check(tag_for(ex_rt, eb), {6'd0, sel_b}, {6'd0, eb});
        check(tag_for(ex_rs, ea), op_a, ea == 2'b10 ? mem_result : ea == 2'b01 ? wb_value : rf_a);
        check(tag_for(ex_rt, eb), op_b, eb == 2'b10 ? mem_result : eb == 2'b01 ? wb_value : rf_b);
        check("R9", {7'd0, sel_a == 2'b11 || sel_b == 2'b11}, 8'd0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule